// File: doc/BRIEF.md
# Rule Vector Evaluator

This block turns the per-field match results of one packet into a rule vector carrying one bit per rule. Upstream lookup tables report, for each header field, which exact-value slots hit and which range tables hit. Each rule is an AND term over the fields. For every field a rule picks one of four tests: ignore the field, require a hit on a chosen slot, require a hit on a chosen range table, or require that a chosen slot did not hit. Several rules may name the same slot or range table, so one table entry serves every rule that tests that value.

The rule definitions sit in configuration registers. Software writes them one (rule, field) pair at a time through a write port. When the match-vector strobe arrives, all rules are evaluated in parallel. The rule vector and its valid pulse are registered and appear on the next clock edge. Downstream logic then acts directly on matching rules and never sees raw field hits.

Top module: `rule_vec_eval`

## Requirements
- R1: After synchronous reset, `rule_vec` is 0, `rv_valid` is 0, and every rule has all fields in mode 2'b00, so no rule can match.
- R2: `rv_valid` is high in exactly the cycle after a cycle with `mv_valid` high. The `rule_vec` evaluated from that strobe's inputs appears in the same cycle.
- R3: In a cycle after one with `mv_valid` low, `rule_vec` keeps its previous value whatever the hit inputs do.
- R4: Bit n of `rule_vec` is 1 only when every field condition of rule n is true and at least one of its fields is not in mode 2'b00.
- R5: Field mode 2'b00 (don't-care) is always true.
- R6: Field mode 2'b01 (slot) is true when `slot_hit[f*SLOTS + sel]` is 1, where f is the field index and sel is the stored selector.
- R7: Field mode 2'b10 (range) is true when `range_hit[f*RANGES + sel]` is 1. It is false when sel >= RANGES.
- R8: Field mode 2'b11 (except) is true when `slot_hit[f*SLOTS + sel]` is 0.
- R9: A rule whose fields are all in mode 2'b00 never sets its bit, even when every hit input is 1.
- R10: A write with `cfg_we` high stores `cfg_mode`/`cfg_sel` for (`cfg_rule`, `cfg_field`). A strobe in the same cycle as the write is evaluated with the previous definition. Strobes in later cycles use the new one.
- R11: A write with `cfg_field` >= NUM_FIELDS changes no rule.
- R12: Rules that name the same slot or range table all see its hit in the same evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule definition write enable |
| cfg_rule | input | RULE_W | Rule index being written |
| cfg_field | input | FIELD_W | Field index being written |
| cfg_mode | input | 2 | Field mode: 00 don't-care, 01 slot, 10 range, 11 except |
| cfg_sel | input | SEL_W | Slot or range-table selector |
| mv_valid | input | 1 | Match-vector strobe for one packet |
| slot_hit | input | NUM_FIELDS*SLOTS | Per-field slot hits, field f at bits f*SLOTS upward |
| range_hit | input | NUM_FIELDS*RANGES | Per-field range-table hits, field f at bits f*RANGES upward |
| rv_valid | output | 1 | Rule vector valid pulse |
| rule_vec | output | NUM_RULES | One bit per matching rule |

## Verification
A configuration write and a match strobe can land in the same cycle. In that case the old rule definition must decide the packet, and the new one must decide the next packet. The bench drives both in one cycle: it clears the slot condition of a rule while sending a packet that misses that slot, then sends the same packet again. The expected vectors are 0 and then 1. The random phase mixes writes and strobes freely, and the behavioural model applies each write only after it has evaluated the strobe in the same cycle.

// File: rtl/rve_pkg.sv
package rve_pkg;
  typedef enum logic [1:0] {
    MODE_ANY    = 2'b00,
    MODE_SLOT   = 2'b01,
    MODE_RANGE  = 2'b10,
    MODE_EXCEPT = 2'b11
  } cond_mode_e;
endpackage

// File: rtl/rve_cfg_store.sv
module rve_cfg_store #(
  parameter int NUM_RULES  = 16,
  parameter int NUM_FIELDS = 3,
  parameter int SEL_W      = 7,
  parameter int RULE_W     = 4,
  parameter int FIELD_W    = 2
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            cfg_we,
  input  logic [RULE_W-1:0]                               cfg_rule,
  input  logic [FIELD_W-1:0]                              cfg_field,
  input  logic [1:0]                                      cfg_mode,
  input  logic [SEL_W-1:0]                                cfg_sel,
  output logic [NUM_RULES-1:0][NUM_FIELDS-1:0][1:0]       mode_o,
  output logic [NUM_RULES-1:0][NUM_FIELDS-1:0][SEL_W-1:0] sel_o,
  output logic [NUM_RULES-1:0]                            en_o
);
  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_RULES; r++) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (rst) begin
          mode_o[r][f] <= 2'b00;
          sel_o[r][f]  <= '0;
        end else if (cfg_we && int'(cfg_rule) == r && int'(cfg_field) == f) begin
          mode_o[r][f] <= cfg_mode;
          sel_o[r][f]  <= cfg_sel;
        end
      end
    end
  end

  // A rule counts as enabled once any of its fields leaves don't-care
  always_comb begin
    for (int r = 0; r < NUM_RULES; r++) begin
      en_o[r] = 1'b0;
      for (int f = 0; f < NUM_FIELDS; f++) en_o[r] = en_o[r] | (|mode_o[r][f]);
    end
  end

  // R10
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_field) < NUM_FIELDS && int'(cfg_rule) < NUM_RULES)
    |=> (mode_o[$past(cfg_rule)][$past(cfg_field)] == $past(cfg_mode)
         && sel_o[$past(cfg_rule)][$past(cfg_field)] == $past(cfg_sel)));

  // R11
  cfg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_field) >= NUM_FIELDS) |=> ($stable(mode_o) && $stable(sel_o)));
endmodule

// File: rtl/rve_cond.sv
module rve_cond
  import rve_pkg::*;
#(
  parameter int SLOTS  = 128,
  parameter int RANGES = 4,
  parameter int SEL_W  = 7
) (
  input  logic [SLOTS-1:0]  slot_hit,
  input  logic [RANGES-1:0] range_hit,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  sel,
  output logic              ok
);
  logic slot_bit;
  logic range_bit;

  // Selector muxes; a selector past the table end reads as no hit
  always_comb begin
    slot_bit  = 1'b0;
    range_bit = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (int'(sel) == i) slot_bit = slot_hit[i];
    for (int i = 0; i < RANGES; i++)
      if (int'(sel) == i) range_bit = range_hit[i];
  end

  always_comb begin
    case (cond_mode_e'(mode))
      MODE_SLOT:   ok = slot_bit;
      MODE_RANGE:  ok = range_bit;
      MODE_EXCEPT: ok = ~slot_bit;
      default:     ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/rve_rule.sv
module rve_rule #(
  parameter int NUM_FIELDS = 3,
  parameter int SLOTS      = 128,
  parameter int RANGES     = 4,
  parameter int SEL_W      = 7
) (
  input  logic [NUM_FIELDS*SLOTS-1:0]            slot_hit,
  input  logic [NUM_FIELDS*RANGES-1:0]           range_hit,
  input  logic [NUM_FIELDS-1:0][1:0]             mode,
  input  logic [NUM_FIELDS-1:0][SEL_W-1:0]       sel,
  input  logic                                   enabled,
  output logic                                   hit
);
  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    rve_cond #(.SLOTS(SLOTS), .RANGES(RANGES), .SEL_W(SEL_W)) u_cond (
      .slot_hit (slot_hit[f*SLOTS +: SLOTS]),
      .range_hit(range_hit[f*RANGES +: RANGES]),
      .mode     (mode[f]),
      .sel      (sel[f]),
      .ok       (field_ok[f])
    );
  end

  assign hit = enabled & (&field_ok);
endmodule

// File: rtl/rule_vec_eval.sv
module rule_vec_eval #(
  parameter int NUM_RULES  = 16,
  parameter int NUM_FIELDS = 3,
  parameter int SLOTS      = 128,
  parameter int RANGES     = 4,
  localparam int SEL_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int RULE_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int FIELD_W   = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [RULE_W-1:0]            cfg_rule,
  input  logic [FIELD_W-1:0]           cfg_field,
  input  logic [1:0]                   cfg_mode,
  input  logic [SEL_W-1:0]             cfg_sel,
  input  logic                         mv_valid,
  input  logic [NUM_FIELDS*SLOTS-1:0]  slot_hit,
  input  logic [NUM_FIELDS*RANGES-1:0] range_hit,
  output logic                         rv_valid,
  output logic [NUM_RULES-1:0]         rule_vec
);
  logic [NUM_RULES-1:0][NUM_FIELDS-1:0][1:0]       rule_mode;
  logic [NUM_RULES-1:0][NUM_FIELDS-1:0][SEL_W-1:0] rule_sel;
  logic [NUM_RULES-1:0]                            rule_en;
  logic [NUM_RULES-1:0]                            hit_vec;

  rve_cfg_store #(
    .NUM_RULES(NUM_RULES), .NUM_FIELDS(NUM_FIELDS), .SEL_W(SEL_W),
    .RULE_W(RULE_W), .FIELD_W(FIELD_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rule(cfg_rule),
    .cfg_field(cfg_field), .cfg_mode(cfg_mode), .cfg_sel(cfg_sel),
    .mode_o(rule_mode), .sel_o(rule_sel), .en_o(rule_en)
  );

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    rve_rule #(
      .NUM_FIELDS(NUM_FIELDS), .SLOTS(SLOTS), .RANGES(RANGES), .SEL_W(SEL_W)
    ) u_rule (
      .slot_hit(slot_hit), .range_hit(range_hit),
      .mode(rule_mode[r]), .sel(rule_sel[r]), .enabled(rule_en[r]),
      .hit(hit_vec[r])
    );

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (mv_valid && !rule_en[r]) |=> !rule_vec[r]);
  end

  // Configuration in the strobe cycle is read before the write lands
  always_ff @(posedge clk) begin
    if (rst) begin
      rv_valid <= 1'b0;
      rule_vec <= '0;
    end else begin
      rv_valid <= mv_valid;
      if (mv_valid) rule_vec <= hit_vec;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mv_valid |=> rv_valid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mv_valid |=> !rv_valid);

  // R3
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mv_valid |=> $stable(rule_vec));
endmodule

// File: tb/rule_vec_eval_bench.sv
module rule_vec_eval_bench;
  localparam int NR = 16;
  localparam int NF = 3;
  localparam int NS = 128;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_rule = '0;
  logic [1:0] cfg_field = '0;
  logic [1:0] cfg_mode = '0;
  logic [6:0] cfg_sel = '0;
  logic mv_valid = 1'b0;
  logic [NF*NS-1:0] slot_hit = '0;
  logic [NF*NG-1:0] range_hit = '0;
  logic rv_valid;
  logic [NR-1:0] rule_vec;

  int checks = 0;
  int errors = 0;
  int m_mode [NR][NF];
  int m_sel  [NR][NF];
  logic [NR-1:0] exp_vec = '0;
  logic exp_val = 1'b0;

  always #5 clk = ~clk;

  rule_vec_eval #(.NUM_RULES(NR), .NUM_FIELDS(NF), .SLOTS(NS), .RANGES(NG)) u_rule_vec_eval (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rule(cfg_rule), .cfg_field(cfg_field),
    .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .mv_valid(mv_valid), .slot_hit(slot_hit),
    .range_hit(range_hit), .rv_valid(rv_valid), .rule_vec(rule_vec)
  );

  function automatic logic [NR-1:0] model_eval(logic [NF*NS-1:0] s, logic [NF*NG-1:0] g);
    logic [NR-1:0] v = '0;
    for (int r = 0; r < NR; r++) begin
      bit ok = 1;
      bit used = 0;
      for (int f = 0; f < NF; f++) begin
        int md = m_mode[r][f];
        int sl = m_sel[r][f];
        if (md != 0) used = 1;
        if (md == 1) ok = ok && s[f*NS + sl];
        if (md == 2) ok = ok && (sl < NG) && g[f*NG + (sl % NG)];
        if (md == 3) ok = ok && !s[f*NS + sl];
      end
      v[r] = ok && used;
    end
    return v;
  endfunction

  task automatic check(string tag);
    checks++;
    if (rv_valid !== exp_val || rule_vec !== exp_vec) begin
      errors++;
      $display("FAIL %s: actual valid=%0b vec=%h expected valid=%0b vec=%h",
               tag, rv_valid, rule_vec, exp_val, exp_vec);
    end
  endtask

  // Called at a falling edge with the inputs already set; checks after one clock
  task automatic step(string tag);
    exp_val = mv_valid;
    if (mv_valid) exp_vec = model_eval(slot_hit, range_hit);
    if (cfg_we && int'(cfg_field) < NF) begin
      m_mode[cfg_rule][cfg_field] = int'(cfg_mode);
      m_sel[cfg_rule][cfg_field]  = int'(cfg_sel);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
    cfg_we   = 1'b0;
    mv_valid = 1'b0;
  endtask

  task automatic cfgw(int r, int f, int md, int sl, string tag);
    cfg_we = 1'b1; cfg_rule = 4'(r); cfg_field = 2'(f);
    cfg_mode = 2'(md); cfg_sel = 7'(sl);
    step(tag);
  endtask

  task automatic clear_hits();
    slot_hit = '0; range_hit = '0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++)
      for (int f = 0; f < NF; f++) begin m_mode[r][f] = 0; m_sel[r][f] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rst = 1'b0;
    // R1 / R9: all rules disabled after reset
    slot_hit = '1; range_hit = '1; mv_valid = 1'b1;
    step("R1 R9 reset rules disabled");
    clear_hits();

    cfgw(0, 0, 1, 7, "R10"); cfgw(0, 1, 2, 2, "R10"); cfgw(0, 2, 1, 127, "R10");
    cfgw(1, 0, 1, 7, "R10"); cfgw(1, 1, 2, 1, "R10"); cfgw(1, 2, 1, 1, "R10");
    cfgw(2, 0, 1, 9, "R10"); cfgw(2, 1, 1, 5, "R10"); cfgw(2, 2, 3, 127, "R10");
    cfgw(3, 1, 2, 5, "R7 out-of-range selector");
    cfgw(4, 3, 1, 0, "R11 bad field write");

    // R12: rules 0 and 1 share slot 7 of field 0
    slot_hit[0*NS+7] = 1; range_hit[1*NG+2] = 1; range_hit[1*NG+1] = 1;
    slot_hit[2*NS+127] = 1; slot_hit[2*NS+1] = 1; mv_valid = 1;
    step("R12 shared slot");
    // R8 except true, R7 out-of-range selector false even with all ranges
    clear_hits(); slot_hit[0*NS+9] = 1; slot_hit[1*NS+5] = 1; range_hit = '1; mv_valid = 1;
    step("R8 except true R7");
    // R8 except false
    slot_hit[2*NS+127] = 1; mv_valid = 1;
    step("R8 except false");
    // R7 range selects one table
    clear_hits(); slot_hit[0*NS+7] = 1; range_hit[1*NG+2] = 1; slot_hit[2*NS+127] = 1; mv_valid = 1;
    step("R7 range");
    // R6 missing slot kills the rule
    slot_hit[0*NS+7] = 0; mv_valid = 1;
    step("R6 slot miss");
    // R11 / R9 / R4: rule 4 stays disabled with everything hitting
    slot_hit = '1; range_hit = '1; mv_valid = 1;
    step("R11 R9 R4 all hits");
    // R3 hold while inputs move
    clear_hits(); step("R3 hold");
    slot_hit[0*NS+7] = 1; step("R3 hold");
    range_hit = '1; step("R3 hold");
    // R10 write and strobe together: old definition decides
    clear_hits(); range_hit[1*NG+2] = 1; slot_hit[2*NS+127] = 1;
    cfg_we = 1; cfg_rule = 0; cfg_field = 0; cfg_mode = 2'b00; cfg_sel = 0; mv_valid = 1;
    step("R10 same-cycle write");
    mv_valid = 1;
    step("R10 R5 new definition");
    // R2: a lone strobe with nothing hitting
    clear_hits(); mv_valid = 1;
    step("R2 strobe");

    // Random mix of writes and strobes
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NF*NS; i++) slot_hit[i] = ($urandom % 4) != 0;
      for (int i = 0; i < NF*NG; i++) range_hit[i] = ($urandom % 4) != 0;
      mv_valid = ($urandom % 2) == 1;
      if ($urandom % 4 == 0) begin
        cfg_we = 1; cfg_rule = 4'($urandom); cfg_field = 2'($urandom);
        cfg_mode = 2'($urandom);
        cfg_sel = ($urandom % 2 == 0) ? 7'($urandom % 8) : 7'($urandom);
      end
      step("R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule